// File: doc/BRIEF.md
# Multi-Mode Serial Baud Rate Generator

This block derives the timing pulses for one serial channel from the system clock. A CPU-visible 8-bit divisor N sets a divide of (N+1). A 2-bit clock-select input picks a power-of-four prescale of 4^n. A 2-bit mode input picks one of three scalings: asynchronous, clock-synchronous or smart-card. In smart-card mode a further 2-bit field chooses how many basic clocks make up one bit.

The block has two single-cycle outputs. The basic-clock tick is the sampling or oversampling pulse. The bit tick marks the boundary of each bit. Every channel uses its own instance.

Internally the system clock runs through a chain of four counters: prescaler, divisor, basic and bit. A unit period lasts 4^n x (N+1) clocks. The basic tick fires every 2 units, or every 4 units in synchronous mode. The bit tick fires once every 16 basic ticks in asynchronous mode, on every basic tick in synchronous mode, and once every S basic ticks in smart-card mode.

Any write of the divisor, or any change of clock select, mode or smart-card field, restarts the chain. The first period after such a change therefore has full length.

Top module: `serial_baud_gen`

## Requirements
- R1: After reset the divisor reads 0xFF, both ticks are low, and the sampled configuration is mode 00, clock select 00 and smart-card field 00.
- R2: When `wr_en_i` is high at a clock edge, the divisor takes `wr_data_i`. `rd_data_o` always shows the current divisor.
- R3: Mode 00 (asynchronous): bit ticks are 32 x 4^n x (N+1) clocks apart and basic ticks are 2 x 4^n x (N+1) clocks apart.
- R4: Mode 01 (clock-synchronous): bit ticks are 4 x 4^n x (N+1) clocks apart, and every basic tick coincides with a bit tick.
- R5: Mode 10 (smart-card): bit ticks are 2 x S x 4^n x (N+1) clocks apart and basic ticks are 2 x 4^n x (N+1) clocks apart. S is 32, 64, 372 or 256 for `bcp_i` values 00, 01, 10 and 11.
- R6: `cks_i` selects n equal to its binary value (00 gives 0, 01 gives 1, 10 gives 2, 11 gives 3).
- R7: A divisor write, or a change of `cks_i`, `mode_i` or `bcp_i`, restarts all counters at that edge. The first bit tick then rises at the edge exactly T clocks later, where T is the bit period of the new setting.
- R8: While `en_i` is low, no tick is produced and the counters hold at zero. The first bit tick after `en_i` rises comes T clocks after the last edge that sampled `en_i` low.
- R9: Each tick is high for one clock, and a bit tick is always accompanied by a basic tick.
- R10: Mode 11 behaves the same as mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| wr_en_i | input | 1 | Divisor write strobe |
| wr_data_i | input | 8 | Divisor write value |
| rd_data_o | output | 8 | Current divisor |
| cks_i | input | 2 | Prescale select, 4^n |
| mode_i | input | 2 | 00 async, 01 sync, 10 smart-card, 11 as async |
| bcp_i | input | 2 | Smart-card basic clocks per bit |
| base_tick_o | output | 1 | Basic-clock tick |
| bit_tick_o | output | 1 | Bit tick |

## Verification
The bench builds the generator with its default parameters: an 8-bit divisor and a 2-bit clock select. These make the full set of prescales 1, 4, 16 and 64 and divisors from 0 to 255 reachable. Its vectors cover every mode, every clock select and every smart-card length. N=0 and N=255 are included, and each vector keeps its bit period short enough to measure. Directed cases restart the chain mid-period and gate it with the enable.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int BIT_W = 9;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_CARD  = 2'b10,
    MODE_ALT   = 2'b11
  } sbg_mode_e;

  // units per basic tick, minus one
  function automatic logic [1:0] base_last(sbg_mode_e m);
    return (m == MODE_SYNC) ? 2'd3 : 2'd1;
  endfunction

  // basic ticks per bit, minus one
  function automatic logic [BIT_W-1:0] bit_last(sbg_mode_e m, logic [1:0] bcp);
    logic [BIT_W-1:0] r;
    unique case (m)
      MODE_SYNC: r = 9'd0;
      MODE_CARD: begin
        unique case (bcp)
          2'b00:   r = 9'd31;
          2'b01:   r = 9'd63;
          2'b10:   r = 9'd371;
          default: r = 9'd255;
        endcase
      end
      default:   r = 9'd15;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sbg_cnt.sv
module sbg_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_comb tick_o = step_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
endmodule

// File: rtl/sbg_limits.sv
module sbg_limits
  import sbg_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1)
) (
  input  sbg_mode_e        mode_i,
  input  logic [SEL_W-1:0] cks_i,
  input  logic [1:0]       bcp_i,
  output logic [PRE_W-1:0] pre_last_o,
  output logic [1:0]       base_last_o,
  output logic [BIT_W-1:0] bit_last_o
);
  logic [PRE_W:0] span;

  always_comb begin
    span        = (PRE_W+1)'(1) << {cks_i, 1'b0};
    pre_last_o  = PRE_W'(span - 1'b1);
    base_last_o = base_last(mode_i);
    bit_last_o  = bit_last(mode_i, bcp_i);
  end
endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen
  import sbg_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter int               SEL_W   = 2,
  parameter logic [DIV_W-1:0] DIV_RST = '1,
  localparam int              PRE_W   = 2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [DIV_W-1:0] wr_data_i,
  output logic [DIV_W-1:0] rd_data_o,
  input  logic [SEL_W-1:0] cks_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       bcp_i,
  output logic             base_tick_o,
  output logic             bit_tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] cks_q;
  sbg_mode_e        mode_q;
  logic [1:0]       bcp_q;
  logic             restart, clr;
  logic [PRE_W-1:0] pre_last;
  logic [1:0]       base_last_w;
  logic [BIT_W-1:0] bit_last_w;
  logic             pre_tick, unit_tick, base_tick, bit_tick;

  // any config edit restarts the chain so the first period is full length
  always_comb begin
    restart = wr_en_i || (cks_i != cks_q) || (sbg_mode_e'(mode_i) != mode_q)
              || (bcp_i != bcp_q);
    clr     = restart || !en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_RST;
      cks_q  <= '0;
      mode_q <= MODE_ASYNC;
      bcp_q  <= '0;
    end else begin
      if (wr_en_i) div_q <= wr_data_i;
      cks_q  <= cks_i;
      mode_q <= sbg_mode_e'(mode_i);
      bcp_q  <= bcp_i;
    end
  end

  assign rd_data_o = div_q;

  sbg_limits #(.SEL_W(SEL_W)) u_limits (
    .mode_i     (mode_q),
    .cks_i      (cks_q),
    .bcp_i      (bcp_q),
    .pre_last_o (pre_last),
    .base_last_o(base_last_w),
    .bit_last_o (bit_last_w)
  );

  sbg_cnt #(.W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .step_i(en_i),
    .last_i(pre_last), .tick_o(pre_tick)
  );
  sbg_cnt #(.W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .step_i(pre_tick),
    .last_i(div_q), .tick_o(unit_tick)
  );
  sbg_cnt #(.W(2)) u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .step_i(unit_tick),
    .last_i(base_last_w), .tick_o(base_tick)
  );
  sbg_cnt #(.W(BIT_W)) u_bit (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .step_i(base_tick),
    .last_i(bit_last_w), .tick_o(bit_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_tick_o <= 1'b0;
      bit_tick_o  <= 1'b0;
    end else begin
      base_tick_o <= base_tick && !clr;
      bit_tick_o  <= bit_tick && !clr;
    end
  end

  assert_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));
  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !base_tick_o && !bit_tick_o);
  assert_bit_on_base_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> base_tick_o);
  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_tick_o |=> !base_tick_o);
endmodule

// File: tb/sim_serial_baud_gen.sv
module sim_serial_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cks = '0, mode = '0, bcp = '0;
  logic       base_tick, bit_tick;
  int         checks = 0, fails = 0, cycles = 0;
  int         c, exp_t, exp_b;
  logic       bad;

  always #5 clk = ~clk;

  serial_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .cks_i(cks),
    .mode_i(mode), .bcp_i(bcp), .base_tick_o(base_tick), .bit_tick_o(bit_tick)
  );

  // {mode, cks, bcp, N}
  localparam logic [13:0] VEC [0:18] = '{
    {2'd0, 2'd0, 2'd0, 8'd0},   {2'd0, 2'd1, 2'd0, 8'd0},
    {2'd0, 2'd2, 2'd0, 8'd0},   {2'd0, 2'd3, 2'd0, 8'd0},
    {2'd0, 2'd0, 2'd0, 8'd255}, {2'd0, 2'd1, 2'd0, 8'd2},
    {2'd1, 2'd0, 2'd0, 8'd0},   {2'd1, 2'd1, 2'd0, 8'd0},
    {2'd1, 2'd2, 2'd0, 8'd3},   {2'd1, 2'd3, 2'd0, 8'd0},
    {2'd1, 2'd0, 2'd0, 8'd255}, {2'd2, 2'd0, 2'd0, 8'd0},
    {2'd2, 2'd0, 2'd1, 8'd0},   {2'd2, 2'd0, 2'd2, 8'd0},
    {2'd2, 2'd0, 2'd3, 8'd1},   {2'd2, 2'd3, 2'd0, 8'd0},
    {2'd2, 2'd1, 2'd2, 8'd1},   {2'd3, 2'd0, 2'd0, 8'd1},
    {2'd3, 2'd2, 2'd1, 8'd0}
  };

  function automatic int card_s(logic [1:0] b);
    case (b)
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 372;
      default: return 256;
    endcase
  endfunction

  function automatic int bit_period(logic [1:0] m, logic [1:0] k, logic [1:0] b, int n);
    int u;
    u = (1 << (2 * k)) * (n + 1);
    case (m)
      2'd1: return 4 * u;
      2'd2: return 2 * card_s(b) * u;
      default: return 32 * u;
    endcase
  endfunction

  function automatic int base_period(logic [1:0] m, logic [1:0] k, int n);
    return ((m == 2'd1) ? 4 : 2) * (1 << (2 * k)) * (n + 1);
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // drive a config plus divisor write, return after the restart edge
  task automatic apply(logic [1:0] m, logic [1:0] k, logic [1:0] b, logic [7:0] n);
    @(negedge clk);
    mode = m; cks = k; bcp = b; wr_data = n; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // negedges until bit tick, counted from the first negedge
  task automatic wait_bit(int lim, output int cnt);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (bit_tick || cnt > lim) break;
      cnt++;
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 190000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 divisor", int'(rd_data), 255);
    check("R1 base tick", int'(base_tick), 0);
    check("R1 bit tick", int'(bit_tick), 0);
    rst_n = 1'b1;
    en = 1'b1;

    foreach (VEC[i]) begin
      logic [1:0] m, k, b;
      int n;
      m = VEC[i][13:12]; k = VEC[i][11:10]; b = VEC[i][9:8]; n = int'(VEC[i][7:0]);
      exp_t = bit_period(m, k, b, n);
      exp_b = base_period(m, k, n);
      apply(m, k, b, 8'(n));
      wait_bit(exp_t + 5, c);
      check({mode_tag(m), " R6 R7 first bit"}, c, exp_t);
      bad = 1'b0;
      c = 0;
      forever begin
        @(negedge clk);
        c++;
        if (bit_tick && !base_tick) bad = 1'b1;
        if (bit_tick || c > exp_t + 5) break;
      end
      check({mode_tag(m), " R6 bit interval"}, c, exp_t);
      c = 0;
      forever begin
        @(negedge clk);
        c++;
        if (base_tick || c > exp_b + 5) break;
      end
      check({mode_tag(m), " base interval"}, c, exp_b);
      @(negedge clk);
      check("R9 one-cycle base", int'(base_tick), 0);
      check("R9 bit with base", int'(bad), 0);
    end

    // R2 register write and readback
    apply(2'd1, 2'd0, 2'd0, 8'd9);
    check("R2 readback", int'(rd_data), 9);

    // R7 rewrite mid-period restarts
    repeat (15) @(negedge clk);
    apply(2'd1, 2'd0, 2'd0, 8'd9);
    wait_bit(60, c);
    check("R7 restart on write", c, 40);
    repeat (7) @(negedge clk);
    apply(2'd0, 2'd0, 2'd0, 8'd9);
    wait_bit(400, c);
    check("R7 restart on mode change", c, 320);

    // R8 enable low holds everything
    apply(2'd1, 2'd0, 2'd0, 8'd4);
    repeat (9) @(negedge clk);
    en = 1'b0;
    bad = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (base_tick || bit_tick) bad = 1'b1;
    end
    check("R8 no ticks while disabled", int'(bad), 0);
    check("R8 divisor kept", int'(rd_data), 4);
    en = 1'b1;
    wait_bit(40, c);
    check("R8 first tick after enable", c, 19);

    finish_run();
  end
endmodule